// File: doc/BRIEF.md
# Serial Keyboard Frame Receiver

This block takes the two open-collector lines of a serial keyboard port, a slow device-driven clock and a data line, into a design that runs on a much faster system clock. It resynchronizes both lines and removes short glitches from the keyboard clock. It then samples the data line on each accepted falling edge of that clock and assembles 11-bit frames. Each frame holds a low start bit, eight data bits with the least significant bit first, an odd parity bit and a high stop bit.

A frame that passes all checks produces the received byte together with a single-cycle valid strobe. A frame with a wrong start, parity or stop bit produces a single-cycle error pulse and is dropped. A frame that stalls mid-way for longer than a timeout window is silently discarded.

The block also keeps a rolling two-byte history of good bytes. A display can therefore show the tail of a multi-byte press or release sequence, for example the release marker F0h followed by the final code byte.

Top module: `ps2_kbd_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `hist_o` reads 0 and neither `byte_valid_o` nor `frame_error_o` is high.
- R2: A frame consists of a start bit of 0 followed by eight data bits. The first data bit after the start bit lands in `byte_o[0]` and the eighth lands in `byte_o[7]`. A good frame raises `byte_valid_o` for exactly one cycle, with `byte_o` holding the byte during that cycle.
- R3: The ninth bit after the start bit is parity. The eight data bits plus this bit must hold an odd number of ones. Otherwise `frame_error_o` pulses for one cycle and `byte_valid_o` stays low for that frame.
- R4: The tenth bit after the start bit is the stop bit and must be 1. A stop bit of 0 pulses `frame_error_o` for one cycle and no byte is reported.
- R5: A falling keyboard clock edge seen while idle with the data line at 1 is a bad start bit. It pulses `frame_error_o` and does not begin a frame.
- R6: One cycle after each `byte_valid_o` pulse, `hist_o[7:0]` holds the new byte and `hist_o[15:8]` holds the value that `hist_o[7:0]` had before.
- R7: `hist_o` changes only in the cycle after a `byte_valid_o` pulse. Error frames and discarded frames leave it unchanged.
- R8: A low pulse on the keyboard clock lasting fewer than `FILT_LEN` system cycles, after the synchronizer, is not treated as an edge.
- R9: Inside a frame, if no accepted falling edge arrives for `TIMEOUT_CYC` system cycles, the partial frame is dropped without any pulse. The next falling edge is then treated as a start bit.
- R10: `byte_valid_o` and `frame_error_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous, idles high |
| kb_dat_i | input | 1 | Keyboard data line, asynchronous, idles high |
| byte_o | output | 8 | Most recently assembled byte |
| byte_valid_o | output | 1 | One-cycle strobe for a good frame |
| frame_error_o | output | 1 | One-cycle pulse for a bad start, parity or stop bit |
| hist_o | output | 16 | Byte history: [7:0] newest, [15:8] previous |

## Verification
Every one of the 256 byte values is sent with correct odd parity. This separates bit-order and shift errors from parity-polarity errors, because each byte exercises a distinct pattern of ones. A byte sweep with inverted parity and frames with a zero stop bit show that each field check rejects on its own and leaves the history untouched. A short clock glitch, a falling edge with the data line high, and a frame abandoned mid-way are each followed by a clean frame. Only a correct filter, start check and timeout let that clean frame decode correctly. A release sequence (E0h, F0h, 74h) confirms that the history exposes the last two bytes.

// File: rtl/ps2_kbd_rx_pkg.sv
package ps2_kbd_rx_pkg;
    localparam int BYTE_W     = 8;
    localparam int TAIL_BITS  = 10; // data, parity and stop after the start bit
    localparam int HIST_DEPTH = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;
endpackage

// File: rtl/ps2_kbd_rx_sync.sv
module ps2_kbd_rx_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic kb_clk_i,
    input  logic kb_dat_i,
    output logic fall_o,
    output logic dat_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] clk_sync;
        logic [SYNC_STAGES-1:0] dat_sync;
        logic                   clk_filt;
        logic [CW-1:0]          run_cnt;
        logic                   fall;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.clk_sync = {s_q.clk_sync[SYNC_STAGES-2:0], kb_clk_i};
        s_d.dat_sync = {s_q.dat_sync[SYNC_STAGES-2:0], kb_dat_i};
        s_d.fall     = 1'b0;
        if (s_q.clk_sync[SYNC_STAGES-1] != s_q.clk_filt) begin
            if (s_q.run_cnt == CW'(FILT_LEN - 1)) begin
                s_d.clk_filt = s_q.clk_sync[SYNC_STAGES-1];
                s_d.run_cnt  = '0;
                s_d.fall     = s_q.clk_filt;
            end else begin
                s_d.run_cnt = s_q.run_cnt + 1'b1;
            end
        end else begin
            s_d.run_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.clk_sync <= '1;
            s_q.dat_sync <= '1;
            s_q.clk_filt <= 1'b1;
            s_q.run_cnt  <= '0;
            s_q.fall     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fall_o = s_q.fall;
    assign dat_o  = s_q.dat_sync[SYNC_STAGES-1];
endmodule

// File: rtl/ps2_kbd_rx_frame.sv
module ps2_kbd_rx_frame
    import ps2_kbd_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic              dat_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              error_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int NW = $clog2(TAIL_BITS + 1);

    typedef struct packed {
        rx_state_e              state;
        logic [NW-1:0]          nbits;
        logic [TAIL_BITS-1:0]   shreg;
        logic [TW-1:0]          idle_tmr;
        logic [BYTE_W-1:0]      data;
        logic                   valid;
        logic                   error;
    } frame_t;

    frame_t f_d, f_q;
    logic [TAIL_BITS-1:0] full_frame;

    always_comb begin
        f_d        = f_q;
        f_d.valid  = 1'b0;
        f_d.error  = 1'b0;
        full_frame = {dat_i, f_q.shreg[TAIL_BITS-1:1]};
        unique case (f_q.state)
            ST_IDLE: begin
                f_d.idle_tmr = '0;
                if (fall_i) begin
                    if (!dat_i) begin
                        f_d.state = ST_RECV;
                        f_d.nbits = '0;
                    end else begin
                        f_d.error = 1'b1;
                    end
                end
            end
            ST_RECV: begin
                if (fall_i) begin
                    f_d.idle_tmr = '0;
                    f_d.shreg    = full_frame;
                    if (f_q.nbits == NW'(TAIL_BITS - 1)) begin
                        f_d.state = ST_IDLE;
                        if ((^full_frame[BYTE_W:0]) && full_frame[BYTE_W+1]) begin
                            f_d.valid = 1'b1;
                            f_d.data  = full_frame[BYTE_W-1:0];
                        end else begin
                            f_d.error = 1'b1;
                        end
                    end else begin
                        f_d.nbits = f_q.nbits + 1'b1;
                    end
                end else if (f_q.idle_tmr == TW'(TIMEOUT_CYC - 1)) begin
                    f_d.state    = ST_IDLE;
                    f_d.idle_tmr = '0;
                end else begin
                    f_d.idle_tmr = f_q.idle_tmr + 1'b1;
                end
            end
            default: f_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign byte_o  = f_q.data;
    assign valid_o = f_q.valid;
    assign error_o = f_q.error;
endmodule

// File: rtl/ps2_kbd_rx_hist.sv
module ps2_kbd_rx_hist
    import ps2_kbd_rx_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_i,
    input  logic [BYTE_W-1:0]            byte_i,
    output logic [HIST_DEPTH*BYTE_W-1:0] hist_o
);
    logic [HIST_DEPTH*BYTE_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (push_i) begin
            hist_d = {hist_q[(HIST_DEPTH-1)*BYTE_W-1:0], byte_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx
    import ps2_kbd_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 8,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        kb_clk_i,
    input  logic        kb_dat_i,
    output logic [7:0]  byte_o,
    output logic        byte_valid_o,
    output logic        frame_error_o,
    output logic [15:0] hist_o
);
    logic fall_s;
    logic dat_s;

    ps2_kbd_rx_sync #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .kb_clk_i(kb_clk_i),
        .kb_dat_i(kb_dat_i),
        .fall_o  (fall_s),
        .dat_o   (dat_s)
    );

    ps2_kbd_rx_frame #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_frame (
        .clk    (clk),
        .rst    (rst),
        .fall_i (fall_s),
        .dat_i  (dat_s),
        .byte_o (byte_o),
        .valid_o(byte_valid_o),
        .error_o(frame_error_o)
    );

    ps2_kbd_rx_hist u_hist (
        .clk   (clk),
        .rst   (rst),
        .push_i(byte_valid_o),
        .byte_i(byte_o),
        .hist_o(hist_o)
    );
endmodule

// File: rtl/ps2_kbd_rx_chk.sv
module ps2_kbd_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  byte_o,
    input logic        byte_valid_o,
    input logic        frame_error_o,
    input logic [15:0] hist_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (hist_o == 16'h0) && !byte_valid_o && !frame_error_o);

    p_valid_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> !byte_valid_o);

    p_error_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        frame_error_o |=> !frame_error_o);

    p_hist_shift_r6: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> (hist_o[15:8] == $past(hist_o[7:0])) && (hist_o[7:0] == $past(byte_o)));

    p_hist_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !byte_valid_o |=> $stable(hist_o));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid_o && frame_error_o));
endmodule

bind ps2_kbd_rx ps2_kbd_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .frame_error_o(frame_error_o),
    .hist_o       (hist_o)
);

// File: tb/tb_ps2_kbd_rx.sv
module tb_ps2_kbd_rx;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 3;
    localparam int TMO        = 200;
    localparam int HALF       = 16;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kb_clk = 1'b1;
    logic        kb_dat = 1'b1;
    logic [7:0]  byte_o;
    logic        byte_valid_o;
    logic        frame_error_o;
    logic [15:0] hist_o;

    int checks = 0;
    int failures = 0;
    int n_valid = 0;
    int n_err = 0;
    int n_both = 0;
    int valid_hi_cycles = 0;
    logic [7:0] last_byte = 8'h0;
    logic [15:0] exp_hist = 16'h0;
    bit done = 1'b0;

    ps2_kbd_rx #(
        .SYNC_STAGES(2),
        .FILT_LEN   (FILT),
        .TIMEOUT_CYC(TMO)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .kb_clk_i     (kb_clk),
        .kb_dat_i     (kb_dat),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .frame_error_o(frame_error_o),
        .hist_o       (hist_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid_o) begin
                n_valid++;
                valid_hi_cycles++;
                last_byte = byte_o;
            end
            if (frame_error_o) n_err++;
            if (byte_valid_o && frame_error_o) n_both++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        kb_dat = b;
        wait_cyc(HALF/2);
        kb_clk = 1'b0;
        wait_cyc(HALF);
        kb_clk = 1'b1;
        wait_cyc(HALF/2);
    endtask

    // bits after the start bit: data LSB first, parity, stop
    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        logic par;
        par = ~(^b) ^ bad_par;
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit(par);
        send_bit(~bad_stop);
        kb_dat = 1'b1;
        wait_cyc(40);
    endtask

    task automatic good_frame(input logic [7:0] b, input string tag);
        int v0, e0;
        v0 = n_valid; e0 = n_err;
        send_frame(b, 1'b0, 1'b0);
        exp_hist = {exp_hist[7:0], b};
        chk(n_valid == v0 + 1, {tag, " valid count"}, n_valid - v0, 1);
        chk(last_byte == b, {tag, " byte"}, last_byte, b);
        chk(n_err == e0, {tag, " no error"}, n_err - e0, 0);
        chk(hist_o == exp_hist, {tag, " hist R6"}, hist_o, exp_hist);
    endtask

    task automatic bad_frame(input logic [7:0] b, input bit bp, input bit bs, input string tag);
        int v0, e0;
        v0 = n_valid; e0 = n_err;
        send_frame(b, bp, bs);
        chk(n_err == e0 + 1, {tag, " error pulse"}, n_err - e0, 1);
        chk(n_valid == v0, {tag, " no valid"}, n_valid - v0, 0);
        chk(hist_o == exp_hist, {tag, " hist unchanged R7"}, hist_o, exp_hist);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired after %0d cycles expected completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v0, e0;
        wait_cyc(2);
        // R1: reset state, sampled while reset held
        chk(hist_o == 16'h0, "R1 hist in reset", hist_o, 0);
        chk(!byte_valid_o && !frame_error_o, "R1 strobes in reset", {byte_valid_o, frame_error_o}, 0);
        rst = 1'b0;
        wait_cyc(10);
        chk(hist_o == 16'h0 && n_valid == 0 && n_err == 0, "R1 after reset", hist_o, 0);

        // R2, R3, R6: every byte value with correct odd parity
        for (int b = 0; b < 256; b++) good_frame(8'(b), "R2 sweep");

        // R3: inverted parity on a spread of bytes
        for (int b = 0; b < 256; b += 17) bad_frame(8'(b), 1'b1, 1'b0, "R3 parity");
        // R4: zero stop bit
        bad_frame(8'h5A, 1'b0, 1'b1, "R4 stop");
        bad_frame(8'hFF, 1'b0, 1'b1, "R4 stop");

        // R5: falling edge while idle with data high
        v0 = n_valid; e0 = n_err;
        send_bit(1'b1);
        wait_cyc(40);
        chk(n_err == e0 + 1, "R5 bad start error", n_err - e0, 1);
        chk(n_valid == v0, "R5 bad start no valid", n_valid - v0, 0);
        good_frame(8'h3C, "R5 follow-up");

        // R8: short clock glitches with data low must not start a frame
        kb_dat = 1'b0;
        wait_cyc(4);
        for (int w = 1; w < FILT; w++) begin
            kb_clk = 1'b0;
            wait_cyc(w);
            kb_clk = 1'b1;
            wait_cyc(8);
        end
        kb_dat = 1'b1;
        wait_cyc(20);
        chk(n_err == e0 + 1, "R8 glitch no error", n_err - e0, 1);
        good_frame(8'hA7, "R8 follow-up");

        // R9: abandoned partial frame
        v0 = n_valid; e0 = n_err;
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        kb_dat = 1'b1;
        wait_cyc(TMO + 100);
        chk(n_valid == v0 && n_err == e0, "R9 silent drop", n_valid - v0 + n_err - e0, 0);
        good_frame(8'hC3, "R9 follow-up");

        // R6: release sequence, history shows last two bytes
        good_frame(8'hE0, "R6 seq");
        good_frame(8'hF0, "R6 seq");
        good_frame(8'h74, "R6 seq");
        chk(hist_o == 16'hF074, "R6 release tail", hist_o, 16'hF074);

        // R2: each valid strobe lasted exactly one cycle; R10: never with error
        chk(valid_hi_cycles == n_valid, "R2 strobe width", valid_hi_cycles, n_valid);
        chk(n_both == 0, "R10 exclusive", n_both, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule